// File: doc/BRIEF.md
# Transfer Acknowledge Termination Generator

This block produces the active-low transfer-acknowledge handshake for transfers that an outside bus master starts into default memory. It watches a one-cycle start strobe. It gates the work on an enable bit that allows acknowledge for outside-master cycles. It then counts a programmable number of wait states and drives acknowledge low for every beat of the transfer. A longword moved through an 8-bit port takes four beats, and those beats are acknowledged on consecutive cycles. A single byte takes one beat.

The acknowledge line is shared, so the block drives it through an output-enable. Acknowledge and its enable both come up in the same cycle. After the last beat the line is actively driven high for one cycle, and only then is the driver turned off. One extra setup cycle always sits between the start strobe and the wait-state count. This gives the decode logic outside the block time to settle.

The block uses no data flow and no valid/ready channel. Every pin is a plain control signal, sampled or driven at the rising clock edge.

Top module: `tack_gen`

## Requirements
- R1: During reset, and immediately when reset is asserted in the middle of a transfer, `ack_n` is 1 and `ack_oe` is 0.
- R2: A start strobe sampled while `ext_ack_en` is 0 starts nothing. `ack_n` stays 1 and `ack_oe` stays 0.
- R3: Take T as the rising edge where `xfer_start`=1 is sampled with `ext_ack_en`=1 and `wait_states`=0. After edge T, outputs stay idle (`ack_n`=1, `ack_oe`=0) for one setup cycle. `ack_n` first reads 0 after edge T+1.
- R4: With `wait_states`=N, the first acknowledge appears N cycles later than in R3, that is, after edge T+1+N. The enable, size and wait-state inputs are captured at edge T. Changing them later has no effect on the running transfer.
- R5: With `xfer_long`=1, `ack_n` stays 0 for exactly 4 consecutive cycles.
- R6: With `xfer_long`=0, `ack_n` is 0 for exactly 1 cycle.
- R7: In the cycle after the last beat, `ack_n`=1 with `ack_oe`=1. In the cycle after that, `ack_oe`=0.
- R8: `ack_oe` is 1 only during acknowledge beats and the single release cycle. Whenever `ack_oe` is 0, `ack_n` is 1.
- R9: A start strobe sampled at any edge while a transfer is in progress is ignored. This includes the edge that ends the release cycle. The earliest accepted strobe is at the edge after the block returns to idle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock, rising edge active |
| rst_n | input | 1 | Asynchronous active-low reset |
| xfer_start | input | 1 | Transfer-start strobe from the outside master, active high |
| xfer_long | input | 1 | 1: longword burst of four byte beats; 0: single byte |
| ext_ack_en | input | 1 | Enable for acknowledge of outside-master transfers |
| wait_states | input | WAIT_W | Wait states inserted before the first beat |
| ack_n | output | 1 | Transfer acknowledge, active low |
| ack_oe | output | 1 | Output-enable of the acknowledge driver |

## Verification
Two functions can fall in the same cycle: the release turnaround of a finished burst and the sampling of a fresh start strobe. The bench raises the strobe so that it is sampled exactly at the edge that ends the release cycle. It also raises the strobe once while beats are still being acknowledged. Both are judged at the pins. `ack_oe` must fall and stay low, and `ack_n` must stay high for the following window. The bench then starts a clean transfer to show the block still accepts work afterwards.

// File: rtl/tack_pkg.sv
package tack_pkg;
  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_SETUP = 3'd1,
    ST_WAIT  = 3'd2,
    ST_ACK   = 3'd3,
    ST_REL   = 3'd4
  } tack_state_e;
endpackage

// File: rtl/tack_cnt.sv
module tack_cnt #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] load_val,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (load)   cnt_q <= load_val;
    else if (dec)    cnt_q <= cnt_q - W'(1);
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/tack_seq.sv
module tack_seq
  import tack_pkg::*;
#(
  parameter int WAIT_W     = 4,
  parameter int BEATS_LONG = 4,
  parameter int BEAT_W     = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_long,
  input  logic              ext_ack_en,
  input  logic [WAIT_W-1:0] wait_states,
  input  logic              w_zero,
  input  logic              b_zero,
  output logic              w_load,
  output logic [WAIT_W-1:0] w_val,
  output logic              w_dec,
  output logic              b_load,
  output logic [BEAT_W-1:0] b_val,
  output logic              b_dec,
  output tack_state_e       state
);
  localparam logic [BEAT_W-1:0] LONG_LAST = BEAT_W'(BEATS_LONG - 1);

  tack_state_e state_q, state_d;
  logic        accept;

  assign accept = (state_q == ST_IDLE) && xfer_start && ext_ack_en;

  // Both counters are loaded at the accepting edge, so later input changes do not matter.
  assign w_load = accept;
  assign w_val  = wait_states;
  assign b_load = accept;
  assign b_val  = xfer_long ? LONG_LAST : '0;

  always_comb begin
    state_d = state_q;
    w_dec   = 1'b0;
    b_dec   = 1'b0;
    unique case (state_q)
      ST_IDLE:  if (accept) state_d = ST_SETUP;
      ST_SETUP: begin
        if (w_zero) state_d = ST_ACK;
        else begin
          w_dec   = 1'b1;
          state_d = ST_WAIT;
        end
      end
      ST_WAIT: begin
        if (w_zero) state_d = ST_ACK;
        else        w_dec   = 1'b1;
      end
      ST_ACK: begin
        if (b_zero) state_d = ST_REL;
        else        b_dec   = 1'b1;
      end
      ST_REL:   state_d = ST_IDLE;
      default:  state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= ST_IDLE;
    else        state_q <= state_d;
  end

  assign state = state_q;
endmodule

// File: rtl/tack_drv.sv
module tack_drv
  import tack_pkg::*;
(
  input  tack_state_e state,
  output logic        ack_n,
  output logic        ack_oe
);
  always_comb begin
    ack_n  = 1'b1;
    ack_oe = 1'b0;
    case (state)
      ST_ACK: begin
        ack_n  = 1'b0;
        ack_oe = 1'b1;
      end
      ST_REL:  ack_oe = 1'b1;
      default: ;
    endcase
  end
endmodule

// File: rtl/tack_gen.sv
module tack_gen
  import tack_pkg::*;
#(
  parameter int WAIT_W     = 4,
  parameter int BEATS_LONG = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer_start,
  input  logic              xfer_long,
  input  logic              ext_ack_en,
  input  logic [WAIT_W-1:0] wait_states,
  output logic              ack_n,
  output logic              ack_oe
);
  localparam int BEAT_W = (BEATS_LONG > 1) ? $clog2(BEATS_LONG) : 1;

  tack_state_e       state;
  logic              w_load, w_dec, w_zero;
  logic              b_load, b_dec, b_zero;
  logic [WAIT_W-1:0] w_val;
  logic [BEAT_W-1:0] b_val;
  logic              busy;

  tack_seq #(.WAIT_W(WAIT_W), .BEATS_LONG(BEATS_LONG), .BEAT_W(BEAT_W)) u_seq (
    .clk(clk), .rst_n(rst_n),
    .xfer_start(xfer_start), .xfer_long(xfer_long),
    .ext_ack_en(ext_ack_en), .wait_states(wait_states),
    .w_zero(w_zero), .b_zero(b_zero),
    .w_load(w_load), .w_val(w_val), .w_dec(w_dec),
    .b_load(b_load), .b_val(b_val), .b_dec(b_dec),
    .state(state)
  );

  tack_cnt #(.W(WAIT_W)) u_wait_cnt (
    .clk(clk), .rst_n(rst_n), .load(w_load), .load_val(w_val),
    .dec(w_dec), .zero(w_zero)
  );

  tack_cnt #(.W(BEAT_W)) u_beat_cnt (
    .clk(clk), .rst_n(rst_n), .load(b_load), .load_val(b_val),
    .dec(b_dec), .zero(b_zero)
  );

  tack_drv u_drv (.state(state), .ack_n(ack_n), .ack_oe(ack_oe));

  assign busy = (state != ST_IDLE);
endmodule

// File: rtl/tack_gen_chk.sv
module tack_gen_chk #(
  parameter int BEATS_LONG = 4
) (
  input logic clk,
  input logic rst_n,
  input logic xfer_start,
  input logic ext_ack_en,
  input logic ack_n,
  input logic ack_oe,
  input logic busy
);
  logic [7:0] run_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)              run_q <= '0;
    else if (ack_n)          run_q <= '0;
    else if (run_q != 8'hff) run_q <= run_q + 8'd1;
  end

  // R8
  idle_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ack_oe |-> ack_n);

  // R8
  oe_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_oe) |-> !ack_n);

  // R7
  turnaround_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && ack_n) |=> !ack_oe);

  // R2
  no_ack_disabled_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && xfer_start && !ext_ack_en) |=> !busy);

  // R3
  setup_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && xfer_start && ext_ack_en) |=> (busy && !ack_oe));

  // R9
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ack_oe && ack_n) |=> !busy);

  // R5
  burst_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
    run_q <= 8'(BEATS_LONG));
endmodule

bind tack_gen tack_gen_chk #(.BEATS_LONG(BEATS_LONG)) u_chk (
  .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .ext_ack_en(ext_ack_en),
  .ack_n(ack_n), .ack_oe(ack_oe), .busy(busy)
);

// File: tb/tack_gen_tb.sv
module tack_gen_tb;
  localparam int WAIT_W = 4;
  localparam int WIN    = 24;
  localparam int NVEC   = 8;
  // {enable, long, wait_states[3:0]}
  localparam logic [5:0] VEC [NVEC] = '{
    6'b11_0000, 6'b10_0000, 6'b11_0011, 6'b10_0111,
    6'b11_1111, 6'b01_0000, 6'b00_0101, 6'b10_0001
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              xfer_start = 1'b0;
  logic              xfer_long = 1'b0;
  logic              ext_ack_en = 1'b0;
  logic [WAIT_W-1:0] wait_states = '0;
  logic              ack_n, ack_oe;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  tack_gen #(.WAIT_W(WAIT_W), .BEATS_LONG(4)) u_dut (
    .clk(clk), .rst_n(rst_n), .xfer_start(xfer_start), .xfer_long(xfer_long),
    .ext_ack_en(ext_ack_en), .wait_states(wait_states),
    .ack_n(ack_n), .ack_oe(ack_oe)
  );

  always #4 clk = ~clk;

  task automatic chk(input logic act, input logic exp, input string req, input string what);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %b expected %b at %0t", req, what, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // One transfer; k counts negedges after the sampling edge T (k=0 is just after T).
  task automatic run_xfer(input bit en, input bit lng, input logic [WAIT_W-1:0] w);
    int n, b;
    n = int'(w);
    b = lng ? 4 : 1;
    @(negedge clk);
    xfer_start = 1'b1; ext_ack_en = en; xfer_long = lng; wait_states = w;
    @(negedge clk);
    xfer_start = 1'b0; ext_ack_en = ~en; xfer_long = ~lng; wait_states = ~w; // R4 captured at T
    for (int k = 0; k < WIN; k++) begin
      logic e_ack, e_oe;
      string tag;
      e_ack = en && (k >= 1 + n) && (k < 1 + n + b);
      e_oe  = en && (k >= 1 + n) && (k <= 1 + n + b);
      if (!en)               tag = "R2";
      else if (k < 1 + n)    tag = (n == 0) ? "R3" : "R4";
      else if (k < 1 + n + b) tag = lng ? "R5" : "R6";
      else                   tag = "R7";
      chk(ack_n, ~e_ack, tag, "ack_n");
      chk(ack_oe, e_oe, (tag == "R7") ? "R7" : "R8", "ack_oe");
      @(negedge clk);
    end
  endtask

  initial begin
    #(200000 * 8);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1 reset state
    repeat (3) @(negedge clk);
    chk(ack_n, 1'b1, "R1", "ack_n in reset");
    chk(ack_oe, 1'b0, "R1", "ack_oe in reset");
    rst_n = 1'b1;
    @(negedge clk);
    chk(ack_oe, 1'b0, "R1", "ack_oe after reset");

    // vector table
    for (int i = 0; i < NVEC; i++)
      run_xfer(VEC[i][5], VEC[i][4], VEC[i][3:0]);

    // R9: strobes during beats and at the end of the release cycle are ignored
    @(negedge clk);
    xfer_start = 1'b1; ext_ack_en = 1'b1; xfer_long = 1'b1; wait_states = '0;
    @(negedge clk);
    xfer_start = 1'b0;
    for (int k = 0; k < 16; k++) begin
      if (k == 2 || k == 5) begin
        xfer_start = 1'b1; xfer_long = 1'b0;
      end else begin
        xfer_start = 1'b0;
      end
      if (k >= 6) begin
        chk(ack_n, 1'b1, "R9", "ack_n after ignored strobe");
        chk(ack_oe, 1'b0, "R9", "ack_oe after ignored strobe");
      end else if (k >= 1 && k <= 4) begin
        chk(ack_n, 1'b0, "R9", "ack_n beat with strobe");
      end else if (k == 5) begin
        chk(ack_oe, 1'b1, "R9", "release cycle with strobe");
      end
      @(negedge clk);
    end
    xfer_start = 1'b0;

    // R9: still accepts after that
    run_xfer(1'b1, 1'b0, 4'd2);

    // R1: reset in the middle of beats
    @(negedge clk);
    xfer_start = 1'b1; ext_ack_en = 1'b1; xfer_long = 1'b1; wait_states = '0;
    @(negedge clk);
    xfer_start = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(ack_n, 1'b0, "R1", "ack_n before mid reset");
    rst_n = 1'b0;
    #1;
    chk(ack_n, 1'b1, "R1", "ack_n at mid reset");
    chk(ack_oe, 1'b0, "R1", "ack_oe at mid reset");
    @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk(ack_oe, 1'b0, "R1", "ack_oe after mid reset");
    run_xfer(1'b1, 1'b1, 4'd1);

    finish_run();
  end
endmodule